// File: doc/BRIEF.md
# Acquisition ring controller

This block manages a ring of acquisition buffers shared between a sample producer and host software. The host starts ring mode with a command write. Incoming samples then fill buffers one after another, with the fill position wrapping back to buffer 0 after the last buffer. Each filled buffer passes to the host and raises a one-cycle interrupt. The host gives a buffer back by writing its index to a release port. A second release port takes a 16-bit mask, one bit per buffer, and covers only the first sixteen buffers.

A bitmap with one bit per buffer records which buffers the host holds. If the next buffer to fill is still held by the host, filling stalls and any sample offered is dropped, which sets a sticky overrun flag. A release that names a buffer the host does not hold changes nothing and sets a sticky error flag. When no trigger arrives, no buffer completes and the block waits without limit, so only a stop command ends ring mode. The memory datapath, DMA and driver software lie outside this block.

Top module: `acq_ring_ctrl`

## Requirements
- R1: During and right after reset, `running`, `waiting`, `irq`, `stall`, `overrun` and `rel_err` are 0, `fill_idx` is 0 and `owned` is all zero.
- R2: A command write with code 12 enters ring mode from any state. It clears `owned`, `fill_idx`, the partial sample count, `overrun` and `rel_err`. Samples offered while not running are ignored. Code 13 while not running, and any code other than 12, 13 or 20, has no effect.
- R3: A buffer completes on its BUF_SAMPLES-th accepted sample. In the next cycle, `irq` is high for exactly one cycle, `done_idx` holds the completed index, and that buffer's bit in `owned` is set.
- R4: `fill_idx` advances by one for each completed buffer and wraps from NBUF-1 to 0.
- R5: `waiting` is set by code 12 and, while running, by code 13. It is cleared in the cycle in which `irq` is raised. It stays set for as long as no buffer completes.
- R6: A write on `rel_wr` naming a buffer whose `owned` bit is set clears that bit. A release and a completion on different buffers in the same cycle both take effect.
- R7: A write on `rel_wr` naming a buffer whose `owned` bit is clear leaves `owned` unchanged and sets `rel_err`, which holds until the next code 12.
- R8: While running, when the buffer at `fill_idx` is host-owned, `stall` is 1 and `smp_ready` is 0. Samples offered then are dropped and set `overrun`, which holds until the next code 12.
- R9: A write on `leg_wr` releases each buffer i, for i below both 16 and NBUF, whose bit i in `leg_mask` is set and which is host-owned. A set bit naming a buffer that is not host-owned sets `rel_err`. Bits at or above NBUF are ignored.
- R10: Code 20 leaves ring mode. It clears `waiting`, `owned`, `fill_idx` and the partial sample count, and keeps `overrun` and `rel_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code: 12 start, 13 wait, 20 stop |
| rel_wr | input | 1 | Release-by-index write strobe |
| rel_idx | input | $clog2(NBUF) | Index of the buffer handed back |
| leg_wr | input | 1 | Release-by-mask write strobe |
| leg_mask | input | 16 | One bit per buffer 0..15 to hand back |
| smp_valid | input | 1 | Producer offers a sample |
| smp_ready | output | 1 | Sample accepted this cycle if valid |
| running | output | 1 | Ring mode active |
| waiting | output | 1 | Host waits for the next buffer completion |
| stall | output | 1 | Next buffer to fill is still host-owned |
| irq | output | 1 | One-cycle buffer-complete pulse |
| done_idx | output | $clog2(NBUF) | Index of the last completed buffer |
| fill_idx | output | $clog2(NBUF) | Buffer currently being filled |
| owned | output | NBUF | Host-ownership bitmap |
| overrun | output | 1 | Sticky: a sample was dropped during a stall |
| rel_err | output | 1 | Sticky: a release named a buffer not host-owned |

## Verification
The hardest state to reach is a full ring. Every buffer must be host-owned, so that the fill position has wrapped onto a buffer the host still holds, and a sample must then arrive and be dropped. The bench runs on a four-buffer, two-sample ring. It completes all four buffers without releasing any, which drives `fill_idx` back to 0 with a stall, and then offers one more sample. It then releases a buffer in the same cycle that another completes, to show that the bitmap's set and clear paths do not interfere.

// File: rtl/acq_ring_pkg.sv
package acq_ring_pkg;

    localparam int LEGACY_BITS = 16;

    typedef enum logic [7:0] {
        CMD_START = 8'd12,
        CMD_WAIT  = 8'd13,
        CMD_STOP  = 8'd20
    } ring_cmd_e;

    typedef struct packed {
        logic start;
        logic wait_nb;
        logic stop;
    } ring_req_t;

    // Only the three defined codes act; wait needs ring mode to be active.
    function automatic ring_req_t decode_cmd(input logic wr, input logic [7:0] code,
                                             input logic running);
        ring_req_t r;
        r.start   = wr && (code == CMD_START);
        r.wait_nb = wr && (code == CMD_WAIT) && running;
        r.stop    = wr && (code == CMD_STOP);
        return r;
    endfunction

endpackage

// File: rtl/acq_cmd_decode.sv
module acq_cmd_decode
    import acq_ring_pkg::*;
(
    input  logic       cmd_wr,
    input  logic [7:0] cmd_code,
    input  logic       running,
    output ring_req_t  req
);
    always_comb begin
        req = decode_cmd(cmd_wr, cmd_code, running);
    end
endmodule

// File: rtl/acq_own_map.sv
module acq_own_map
    import acq_ring_pkg::*;
#(
    parameter int NBUF = 64,
    localparam int IDXW = $clog2(NBUF)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   map_clr,
    input  logic                   err_clr,
    input  logic                   set_en,
    input  logic [IDXW-1:0]        set_idx,
    input  logic                   rel_wr,
    input  logic [IDXW-1:0]        rel_idx,
    input  logic                   leg_wr,
    input  logic [LEGACY_BITS-1:0] leg_mask,
    output logic [NBUF-1:0]        owned,
    output logic                   rel_err
);
    localparam logic [IDXW:0] NBUF_C = (IDXW + 1)'(NBUF);

    logic [NBUF-1:0] set_vec;
    logic [NBUF-1:0] idx_vec;
    logic [NBUF-1:0] leg_vec;
    logic            idx_in_range;
    logic            idx_bad;
    logic            leg_bad;

    assign idx_in_range = ({1'b0, rel_idx} < NBUF_C);

    for (genvar i = 0; i < NBUF; i++) begin : g_bit
        assign set_vec[i] = set_en && (set_idx == IDXW'(i));
        assign idx_vec[i] = rel_wr && (rel_idx == IDXW'(i));
        if (i < LEGACY_BITS) begin : g_leg
            assign leg_vec[i] = leg_wr && leg_mask[i];
        end else begin : g_noleg
            assign leg_vec[i] = 1'b0;
        end
    end

    // A release of a buffer the host does not hold is a no-op plus an error.
    assign idx_bad = rel_wr && (!idx_in_range || ((idx_vec & owned) == '0));
    assign leg_bad = (leg_vec & ~owned) != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            owned   <= '0;
            rel_err <= 1'b0;
        end else begin
            if (map_clr) begin
                owned <= '0;
            end else begin
                owned <= (owned & ~idx_vec & ~leg_vec) | set_vec;
            end
            if (err_clr) begin
                rel_err <= 1'b0;
            end else if (idx_bad || leg_bad) begin
                rel_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/acq_fill_ctrl.sv
module acq_fill_ctrl
    import acq_ring_pkg::*;
#(
    parameter int NBUF        = 64,
    parameter int BUF_SAMPLES = 1024,
    localparam int IDXW = $clog2(NBUF),
    localparam int CNTW = (BUF_SAMPLES > 1) ? $clog2(BUF_SAMPLES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  ring_req_t       req,
    input  logic            fill_owned,
    input  logic            smp_valid,
    output logic            smp_ready,
    output logic            running,
    output logic            waiting,
    output logic            stall,
    output logic            irq,
    output logic            complete,
    output logic [IDXW-1:0] done_idx,
    output logic [IDXW-1:0] fill_idx,
    output logic            overrun
);
    localparam logic [CNTW-1:0] LAST_CNT = CNTW'(BUF_SAMPLES - 1);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NBUF - 1);

    logic [CNTW-1:0] cnt;
    logic            accept;
    logic            ctl;
    logic            drop;

    assign ctl       = req.start || req.stop;
    assign stall     = running && fill_owned;
    assign smp_ready = running && !fill_owned && !ctl;
    assign accept    = smp_ready && smp_valid;
    assign complete  = accept && (cnt == LAST_CNT);
    assign drop      = stall && smp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            waiting  <= 1'b0;
            irq      <= 1'b0;
            cnt      <= '0;
            fill_idx <= '0;
            done_idx <= '0;
            overrun  <= 1'b0;
        end else begin
            overrun <= req.start ? 1'b0 : (overrun || drop);
            if (ctl) begin
                running  <= req.start;
                waiting  <= req.start;
                irq      <= 1'b0;
                cnt      <= '0;
                fill_idx <= '0;
            end else begin
                irq <= complete;
                if (accept) begin
                    if (complete) begin
                        cnt      <= '0;
                        done_idx <= fill_idx;
                        fill_idx <= (fill_idx == LAST_IDX) ? '0 : fill_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (req.wait_nb) begin
                    waiting <= 1'b1;
                end else if (complete) begin
                    waiting <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/acq_ring_ctrl.sv
module acq_ring_ctrl
    import acq_ring_pkg::*;
#(
    parameter int NBUF        = 64,
    parameter int BUF_SAMPLES = 1024,
    localparam int IDXW = $clog2(NBUF)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_wr,
    input  logic [7:0]             cmd_code,
    input  logic                   rel_wr,
    input  logic [IDXW-1:0]        rel_idx,
    input  logic                   leg_wr,
    input  logic [LEGACY_BITS-1:0] leg_mask,
    input  logic                   smp_valid,
    output logic                   smp_ready,
    output logic                   running,
    output logic                   waiting,
    output logic                   stall,
    output logic                   irq,
    output logic [IDXW-1:0]        done_idx,
    output logic [IDXW-1:0]        fill_idx,
    output logic [NBUF-1:0]        owned,
    output logic                   overrun,
    output logic                   rel_err
);
    ring_req_t req;
    logic      complete;

    acq_cmd_decode u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_code (cmd_code),
        .running  (running),
        .req      (req)
    );

    acq_fill_ctrl #(
        .NBUF        (NBUF),
        .BUF_SAMPLES (BUF_SAMPLES)
    ) u_fill (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .fill_owned (owned[fill_idx]),
        .smp_valid  (smp_valid),
        .smp_ready  (smp_ready),
        .running    (running),
        .waiting    (waiting),
        .stall      (stall),
        .irq        (irq),
        .complete   (complete),
        .done_idx   (done_idx),
        .fill_idx   (fill_idx),
        .overrun    (overrun)
    );

    acq_own_map #(
        .NBUF (NBUF)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .map_clr  (req.start || req.stop),
        .err_clr  (req.start),
        .set_en   (complete),
        .set_idx  (fill_idx),
        .rel_wr   (rel_wr),
        .rel_idx  (rel_idx),
        .leg_wr   (leg_wr),
        .leg_mask (leg_mask),
        .owned    (owned),
        .rel_err  (rel_err)
    );
endmodule

// File: rtl/acq_ring_chk.sv
module acq_ring_chk #(
    parameter int NBUF        = 64,
    parameter int BUF_SAMPLES = 1024,
    localparam int IDXW = $clog2(NBUF)
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_wr,
    input logic [7:0]      cmd_code,
    input logic            rel_wr,
    input logic [IDXW-1:0] rel_idx,
    input logic            smp_valid,
    input logic            smp_ready,
    input logic            running,
    input logic            stall,
    input logic            irq,
    input logic [IDXW-1:0] done_idx,
    input logic [IDXW-1:0] fill_idx,
    input logic [NBUF-1:0] owned,
    input logic            overrun,
    input logic            rel_err
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NBUF - 1);

    logic start_w;
    logic stop_w;
    assign start_w = cmd_wr && (cmd_code == 8'd12);
    assign stop_w  = cmd_wr && (cmd_code == 8'd20);

    assert_irq_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(smp_ready && smp_valid));

    assert_irq_marks_owned_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> owned[done_idx]);

    assert_fill_follows_done_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> fill_idx == ((done_idx == LAST_IDX) ? '0 : done_idx + 1'b1));

    assert_bad_release_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (rel_wr && !owned[rel_idx] && !start_w) |=> rel_err);

    assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> !smp_ready);

    assert_drop_sets_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        (stall && smp_valid && !start_w) |=> overrun);

    assert_stop_clears_R10: assert property (@(posedge clk) disable iff (rst)
        stop_w |=> (!running && owned == '0 && fill_idx == '0));
endmodule

bind acq_ring_ctrl acq_ring_chk #(
    .NBUF        (NBUF),
    .BUF_SAMPLES (BUF_SAMPLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_code  (cmd_code),
    .rel_wr    (rel_wr),
    .rel_idx   (rel_idx),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .running   (running),
    .stall     (stall),
    .irq       (irq),
    .done_idx  (done_idx),
    .fill_idx  (fill_idx),
    .owned     (owned),
    .overrun   (overrun),
    .rel_err   (rel_err)
);

// File: tb/test_acq_ring_ctrl.sv
module test_acq_ring_ctrl;
    localparam int NB = 4;
    localparam int NS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        rel_wr = 1'b0;
    logic [1:0]  rel_idx = '0;
    logic        leg_wr = 1'b0;
    logic [15:0] leg_mask = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, running, waiting, stall, irq, overrun, rel_err;
    logic [1:0]  done_idx, fill_idx;
    logic [3:0]  owned;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    acq_ring_ctrl #(.NBUF(NB), .BUF_SAMPLES(NS)) i_acq_ring_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .rel_wr(rel_wr), .rel_idx(rel_idx), .leg_wr(leg_wr), .leg_mask(leg_mask),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .running(running),
        .waiting(waiting), .stall(stall), .irq(irq), .done_idx(done_idx),
        .fill_idx(fill_idx), .owned(owned), .overrun(overrun), .rel_err(rel_err)
    );

    // [23:20] req, [19] cmd_wr, [18:11] code, [10] rel_wr, [9:8] rel_idx, [7] smp,
    // expected after the edge: [6] irq, [5:4] fill_idx, [3] stall, [2] overrun, [1] rel_err, [0] running
    localparam int NV = 20;
    localparam logic [23:0] VEC [NV] = '{
        {4'd2,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 idle sample ignored
        {4'd2,  1'b1, 8'd12, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 start
        {4'd3,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
        {4'd3,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 buffer 0 done
        {4'd4,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
        {4'd4,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
        {4'd4,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
        {4'd4,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
        {4'd4,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
        {4'd4,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 wrap, ring full
        {4'd8,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 dropped sample
        {4'd6,  1'b0, 8'd0,  1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 release 0
        {4'd7,  1'b0, 8'd0,  1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 release 0 again
        {4'd3,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3
        {4'd6,  1'b0, 8'd0,  1'b1, 2'd1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1}, // R6 release 1 with completion
        {4'd5,  1'b1, 8'd13, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 wait code
        {4'd10, 1'b1, 8'd20, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R10 stop keeps flags
        {4'd2,  1'b0, 8'd0,  1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 idle sample
        {4'd2,  1'b1, 8'd12, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 restart clears
        {4'd2,  1'b1, 8'd99, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}  // R2 unknown code
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic cw, input logic [7:0] code, input logic rw,
                       input logic [1:0] ri, input logic lw, input logic [15:0] lm,
                       input logic sv);
        @(negedge clk);
        cmd_wr = cw; cmd_code = code; rel_wr = rw; rel_idx = ri;
        leg_wr = lw; leg_mask = lm; smp_valid = sv;
        @(posedge clk);
        #1;
        cmd_wr = 1'b0; cmd_code = '0; rel_wr = 1'b0; rel_idx = '0;
        leg_wr = 1'b0; leg_mask = '0; smp_valid = 1'b0;
    endtask

    task automatic idle();
        cyc(1'b0, 8'd0, 1'b0, 2'd0, 1'b0, 16'd0, 1'b0);
    endtask

    task automatic smp();
        cyc(1'b0, 8'd0, 1'b0, 2'd0, 1'b0, 16'd0, 1'b1);
    endtask

    task automatic cmd(input logic [7:0] code);
        cyc(1'b1, code, 1'b0, 2'd0, 1'b0, 16'd0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "running", running, 0);
        chk("R1", "waiting", waiting, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "flags", {stall, overrun, rel_err}, 0);
        chk("R1", "fill_idx", fill_idx, 0);
        chk("R1", "owned", owned, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL all watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        do_reset();

        // Table walk: one cycle per vector, outputs sampled after the edge.
        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            logic [6:0]  got;
            e = VEC[v];
            cyc(e[19], e[18:11], e[10], e[9:8], 1'b0, 16'd0, e[7]);
            got = {irq, fill_idx, stall, overrun, rel_err, running};
            checks++;
            if (got != e[6:0]) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual=%b expected=%b", e[23:20], v, got, e[6:0]);
            end
        end

        // Directed tests
        do_reset();
        cmd(8'd13);
        chk("R2", "wait code while idle", {running, waiting}, 0);
        cmd(8'd12);
        chk("R5", "waiting after start", waiting, 1);
        smp();
        chk("R3", "no irq mid buffer", irq, 0);
        smp();
        chk("R3", "irq at completion", irq, 1);
        chk("R3", "done_idx", done_idx, 0);
        chk("R3", "owned after completion", owned, 4'b0001);
        chk("R5", "waiting cleared by irq", waiting, 0);
        idle();
        chk("R3", "irq lasts one cycle", irq, 0);
        cmd(8'd13);
        chk("R5", "waiting after wait code", waiting, 1);
        repeat (4) smp();
        chk("R3", "done_idx second buffer", done_idx, 2);
        chk("R4", "fill_idx", fill_idx, 3);
        chk("R9", "owned before mask", owned, 4'b0111);
        cyc(1'b0, 8'd0, 1'b0, 2'd0, 1'b1, 16'h0025, 1'b0);
        chk("R9", "mask release, bit 5 ignored", owned, 4'b0010);
        chk("R9", "no error from valid mask", rel_err, 0);
        cyc(1'b0, 8'd0, 1'b0, 2'd0, 1'b1, 16'h0001, 1'b0);
        chk("R9", "mask on free buffer sets error", rel_err, 1);
        chk("R9", "owned unchanged", owned, 4'b0010);
        cmd(8'd20);
        chk("R10", "stop running/waiting", {running, waiting}, 0);
        chk("R10", "stop clears owned", owned, 0);
        chk("R10", "stop clears fill_idx", fill_idx, 0);
        chk("R10", "stop keeps rel_err", rel_err, 1);

        // No trigger: waits indefinitely until stop.
        cmd(8'd12);
        cmd(8'd13);
        repeat (20) idle();
        chk("R5", "still waiting without samples", {running, waiting, irq}, 3'b110);

        // Partial count discarded by stop.
        smp();
        cmd(8'd20);
        cmd(8'd12);
        smp();
        chk("R10", "partial count discarded", irq, 0);
        smp();
        chk("R10", "fresh buffer completes", irq, 1);
        chk("R10", "fresh buffer index", done_idx, 0);

        finish_run();
    end
endmodule